// File: doc/BRIEF.md
# Dual-Mode Host Register Interface

This block is a slave port through which a local host processor reads and writes an on-chip register file. The same pins serve two strobe conventions, chosen by a static mode input. In Intel style the host pulses separate active-low read and write strobes. In Motorola style it pulses one active-low data strobe and gives the direction on a read/write level. An active-low chip select qualifies every access.

All control pins are brought into the internal clock domain through two flip-flop stages. A write takes effect once, on the first synchronized cycle of the access. A read captures the addressed word into a holding register at its start and presents it on the output data bus, with an output enable that an outside pad ring uses to drive or release the shared bus. The address is 9 bits wide and the data 16 bits wide. A bank of mapped words sits behind the port; addresses above the mapped range read as zero and ignore writes.

Top module: `hostbus_regif`

## Requirements
- R1: After reset every mapped word reads 0, `dout_oe` is 0 and `dout` is 0.
- R2: While `cs_n` is 1, no strobe activity writes a word or raises `dout_oe`.
- R3: In Intel mode (`mode_sel`=0) with `cs_n`=0, holding `strb_n` low raises `dout_oe` and drives the addressed word on `dout` no later than 4 clock cycles after the strobe falls.
- R4: No later than 4 clock cycles after the read strobe rises `dout_oe` returns to 0, and `dout` is 0 whenever `dout_oe` is 0.
- R5: In Intel mode with `cs_n`=0, holding `wr_rw` low stores `din` into the word at `addr`.
- R6: In Motorola mode (`mode_sel`=1) with `cs_n`=0, `strb_n` low acts as the data strobe: `wr_rw`=1 performs a read and `wr_rw`=0 a write; `wr_rw` low without the data strobe writes nothing.
- R7: A write commits exactly once per strobe assertion, taking `din` from the first synchronized cycle; later changes of `din` during the same strobe are not stored.
- R8: Read data is captured when the read begins and stays unchanged on `dout` for the whole strobe, even if `addr` changes.
- R9: The address `addr[8:0]` selects words 0 to 383 (bit 8 is the most significant bit); addresses 384 to 511 read as 0 and writes to them are discarded.
- R10: The mode input reinterprets the pins: in Intel mode `wr_rw` low is a write strobe on its own, in Motorola mode it is only a direction level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 1 | Bus style: 0 Intel, 1 Motorola (static) |
| cs_n | input | 1 | Active-low chip select |
| strb_n | input | 1 | Intel read strobe / Motorola data strobe, active low |
| wr_rw | input | 1 | Intel write strobe (active low) / Motorola direction (1 read, 0 write) |
| addr | input | 9 | Word address, bit 8 most significant |
| din | input | 16 | Write data from the host bus |
| dout | output | 16 | Read data toward the host bus |
| dout_oe | output | 1 | Output enable for the bus drivers |

## Verification
The bench goes after a write strobe held long while `din` changes: a design that commits on the level instead of the edge stores the late value. It moves `addr` during an active read, which a design reading the bank combinationally would follow onto the bus, and it pulses the direction level in Motorola mode without a data strobe, which a design that left the Intel decode in place would take as a write. It also writes to the last mapped word, the first unmapped word and a word differing only in bit 8, catching range checks that are off by one or decoders that drop the top address bit.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

  typedef enum logic {
    BUS_INTEL = 1'b0,
    BUS_MOTO  = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic sel_n;
    logic strb_n;
    logic dir;
  } ctl_pins_t;

  localparam int unsigned CTL_W = $bits(ctl_pins_t);

endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= IDLE;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= IDLE;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/hbr_decode.sv
module hbr_decode
  import hbr_pkg::*;
(
  input  bus_mode_e mode_i,
  input  ctl_pins_t pins_i,
  output logic      rd_lvl_o,
  output logic      wr_lvl_o
);

  logic selected;

  always_comb begin
    selected = ~pins_i.sel_n;
    rd_lvl_o = 1'b0;
    wr_lvl_o = 1'b0;
    unique case (mode_i)
      BUS_INTEL: begin
        rd_lvl_o = selected & ~pins_i.strb_n;
        wr_lvl_o = selected & ~pins_i.dir;
      end
      BUS_MOTO: begin
        rd_lvl_o = selected & ~pins_i.strb_n &  pins_i.dir;
        wr_lvl_o = selected & ~pins_i.strb_n & ~pins_i.dir;
      end
      default: begin
        rd_lvl_o = 1'b0;
        wr_lvl_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/hbr_regbank.sv
module hbr_regbank #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] word_q [DEPTH];
  logic              wr_hit;
  logic              rd_hit;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;

  always_comb begin
    wr_hit = ({1'b0, wr_addr_i} < LIMIT);
    rd_hit = ({1'b0, rd_addr_i} < LIMIT);
    wr_idx = IDX_W'(wr_addr_i);
    rd_idx = IDX_W'(rd_addr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
    end else if (wr_en_i && wr_hit) begin
      word_q[wr_idx] <= wr_data_i;
    end
  end

  assign rd_data_o = rd_hit ? word_q[rd_idx] : '0;

endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif
  import hbr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned REG_DEPTH   = 384,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              cs_n,
  input  logic              strb_n,
  input  logic              wr_rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  localparam int unsigned RST_STAGES = 2;

  // reset: asserted at once, released on the clock
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  // control pins into the clock domain
  ctl_pins_t pins_raw;
  ctl_pins_t pins_s;
  logic [CTL_W-1:0] pins_s_vec;

  assign pins_raw = '{sel_n: cs_n, strb_n: strb_n, dir: wr_rw};

  hbr_sync #(
    .WIDTH  (CTL_W),
    .STAGES (SYNC_STAGES),
    .IDLE   ({CTL_W{1'b1}})
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (pins_raw),
    .sync_o  (pins_s_vec)
  );
  assign pins_s = ctl_pins_t'(pins_s_vec);

  logic cs_s;
  assign cs_s = pins_s.sel_n;

  // strobe interpretation by bus style
  bus_mode_e mode;
  logic      rd_lvl;
  logic      wr_lvl;

  assign mode = bus_mode_e'(mode_sel);

  hbr_decode u_decode (
    .mode_i   (mode),
    .pins_i   (pins_s),
    .rd_lvl_o (rd_lvl),
    .wr_lvl_o (wr_lvl)
  );

  // edge detect, holding register, output enable
  logic              rd_q, rd_d;
  logic              wr_q, wr_d;
  logic              oe_q, oe_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              rd_start;
  logic              bank_we;
  logic [DATA_W-1:0] bank_rdata;

  always_comb begin
    rd_start = rd_lvl & ~rd_q;
    bank_we  = wr_lvl & ~wr_q;
    rd_d     = rd_lvl;
    wr_d     = wr_lvl;
    oe_d     = rd_lvl;
    hold_d   = hold_q;
    if (rd_start) hold_d = bank_rdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      oe_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      oe_q   <= oe_d;
      hold_q <= hold_d;
    end
  end

  hbr_regbank #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (REG_DEPTH)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en_i   (bank_we),
    .wr_addr_i (addr),
    .wr_data_i (din),
    .rd_addr_i (addr),
    .rd_data_o (bank_rdata)
  );

  assign dout_oe = oe_q;
  assign dout    = oe_q ? hold_q : '0;

endmodule

// File: rtl/hostbus_regif_chk.sv
module hostbus_regif_chk #(
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned REG_DEPTH = 384
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              mode_sel,
  input logic              cs_s,
  input logic              rd_lvl,
  input logic              wr_lvl,
  input logic              bank_we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(REG_DEPTH);

  assert_cs_gate_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(dout_oe) |-> !$past(cs_s));

  assert_single_commit_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    bank_we |=> !bank_we);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dout_oe && $past(dout_oe)) |-> $stable(dout));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(dout_oe) && ({1'b0, $past(addr)} >= LIMIT)) |-> (dout == '0));

  assert_moto_excl_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode_sel |-> !(rd_lvl && wr_lvl));

endmodule

bind hostbus_regif hostbus_regif_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .REG_DEPTH (REG_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .mode_sel  (mode_sel),
  .cs_s      (cs_s),
  .rd_lvl    (rd_lvl),
  .wr_lvl    (wr_lvl),
  .bank_we   (bank_we),
  .addr      (addr),
  .dout      (dout),
  .dout_oe   (dout_oe)
);

// File: tb/hostbus_regif_tb.sv
`timescale 1ns/1ps
module hostbus_regif_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_sel;
  logic        cs_n;
  logic        strb_n;
  logic        wr_rw;
  logic [8:0]  addr;
  logic [15:0] din;
  logic [15:0] dout;
  logic        dout_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hostbus_regif u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
    .strb_n(strb_n), .wr_rw(wr_rw), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  // entry: [26] mode (0 Intel, 1 Motorola), [25] write, [24:16] addr, [15:0] data/expected
  localparam int NVEC = 17;
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 9'd3,   16'hA5A5},  // R5 Intel write
    {1'b0, 1'b0, 9'd3,   16'hA5A5},  // R3 Intel read
    {1'b1, 1'b1, 9'd10,  16'h1234},  // R6 Motorola write
    {1'b1, 1'b0, 9'd10,  16'h1234},  // R6 Motorola read
    {1'b0, 1'b0, 9'd10,  16'h1234},
    {1'b1, 1'b0, 9'd3,   16'hA5A5},
    {1'b0, 1'b1, 9'd383, 16'hFFFF},  // R9 last mapped word
    {1'b0, 1'b0, 9'd383, 16'hFFFF},
    {1'b1, 1'b1, 9'd384, 16'hBEEF},  // R9 first unmapped word
    {1'b1, 1'b0, 9'd384, 16'h0000},
    {1'b0, 1'b1, 9'd511, 16'h7777},
    {1'b0, 1'b0, 9'd511, 16'h0000},
    {1'b0, 1'b1, 9'd0,   16'h0001},
    {1'b1, 1'b0, 9'd0,   16'h0001},
    {1'b1, 1'b1, 9'd256, 16'h8000},  // R9 bit 8 decoded
    {1'b0, 1'b0, 9'd256, 16'h8000},
    {1'b0, 1'b0, 9'd0,   16'h0001}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_pins();
    cs_n = 1'b1; strb_n = 1'b1; wr_rw = 1'b1;
  endtask

  task automatic bus_access(input logic mode, input logic wr, input logic [8:0] a,
                            input logic [15:0] d, input string tag);
    mode_sel = mode; addr = a; din = d; cs_n = 1'b0;
    if (mode == 1'b0) begin
      if (wr) wr_rw = 1'b0; else strb_n = 1'b0;
    end else begin
      wr_rw = ~wr; strb_n = 1'b0;
    end
    repeat (4) @(negedge clk);
    if (wr) chk({tag, " R4 no drive on write"}, {15'd0, dout_oe}, 16'd0);
    else begin
      chk({tag, " R3 oe"}, {15'd0, dout_oe}, 16'd1);
      chk({tag, " R3 data"}, dout, d);
    end
    strb_n = 1'b1; wr_rw = 1'b1;
    repeat (4) @(negedge clk);
    if (!wr) begin
      chk({tag, " R4 oe released"}, {15'd0, dout_oe}, 16'd0);
      chk({tag, " R4 dout idle"}, dout, 16'd0);
    end
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_pins();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    mode_sel = 1'b0; addr = '0; din = '0;
    do_reset();

    // R1 reset state
    chk("R1 oe after reset", {15'd0, dout_oe}, 16'd0);
    chk("R1 dout after reset", dout, 16'd0);
    bus_access(1'b0, 1'b0, 9'd7, 16'h0000, "R1 word zero");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      bus_access(VEC[i][26], VEC[i][25], VEC[i][24:16], VEC[i][15:0], $sformatf("vec%0d", i));
    end

    // R2 chip select high: write strobe and read strobe ignored
    mode_sel = 1'b0; addr = 9'd7; din = 16'h1111; cs_n = 1'b1; wr_rw = 1'b0;
    repeat (5) @(negedge clk);
    wr_rw = 1'b1; strb_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 oe with cs high", {15'd0, dout_oe}, 16'd0);
    idle_pins();
    repeat (4) @(negedge clk);
    bus_access(1'b0, 1'b0, 9'd7, 16'h0000, "R2 no write");

    // R7 single commit with din changing under a held strobe
    mode_sel = 1'b0; addr = 9'd20; din = 16'hAAAA; cs_n = 1'b0; wr_rw = 1'b0;
    repeat (4) @(negedge clk);
    din = 16'h5555;
    repeat (4) @(negedge clk);
    idle_pins();
    repeat (4) @(negedge clk);
    bus_access(1'b0, 1'b0, 9'd20, 16'hAAAA, "R7 first value kept");

    // R8 read data held while addr moves
    mode_sel = 1'b0; addr = 9'd3; cs_n = 1'b0; strb_n = 1'b0;
    repeat (4) @(negedge clk);
    addr = 9'd10;
    repeat (4) @(negedge clk);
    chk("R8 held data", dout, 16'hA5A5);
    idle_pins();
    repeat (4) @(negedge clk);

    // R6 / R10 direction level alone in Motorola mode writes nothing
    mode_sel = 1'b1; addr = 9'd30; din = 16'h9999; cs_n = 1'b0; wr_rw = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 oe on level only", {15'd0, dout_oe}, 16'd0);
    idle_pins();
    repeat (4) @(negedge clk);
    bus_access(1'b1, 1'b0, 9'd30, 16'h0000, "R6 level only no write");
    // R10 same level in Intel mode is a write strobe
    bus_access(1'b0, 1'b1, 9'd30, 16'h9999, "R10 Intel write");
    bus_access(1'b1, 1'b0, 9'd30, 16'h9999, "R10 readback");

    // R1 reset clears stored words
    do_reset();
    bus_access(1'b0, 1'b0, 9'd3, 16'h0000, "R1 cleared");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule